// File: doc/BRIEF.md
# Fused-Addition SHA-256 Round Stage

This block performs one fully unrolled SHA-256 compression round. One copy is placed per round in a hash pipeline that takes a new nonce every cycle. Each copy takes the eight 32-bit working variables and a word that already holds the sum of this round's constant and schedule word. It returns the updated working variables. It also forms, one stage early, the constant-plus-schedule sum that the following round will consume.

Every chain of additions whose partial sums are not needed elsewhere goes through 3:2 carry-save compressors. Each of the two new working variables is therefore resolved by a single ripple-carry adder. The rotation amounts are plain wiring. The constant of the following round is a per-instance parameter. A valid flag and a 32-bit nonce tag travel beside the data. Only the flag is cleared by reset.

Top module: `sha256_fused_round`

## Requirements
- R1: A synchronous reset drives `outValid` to 0 at the next edge. While reset is high, `outState`, `outKw` and `outNonce` keep their values and ignore the inputs.
- R2: `outValid` equals the `inValid` of the previous cycle. A new input is accepted on every cycle, with no gaps.
- R3: `outNonce` is the `inNonce` that was accepted with the same valid input, unchanged.
- R4: The new `a` (`outState[255:224]`) equals h + S1(e) + Ch(e,f,g) + kw + S0(a) + Maj(a,b,c) mod 2^32. Here S0(x) = ror2^ror13^ror22, S1(x) = ror6^ror11^ror25, Ch = (e&f)^(~e&g) and Maj = (a&b)^(a&c)^(b&c). The state is packed a..h from bit 255 down to bit 0.
- R5: The new `e` (`outState[127:96]`) equals d + h + S1(e) + Ch(e,f,g) + kw mod 2^32.
- R6: The output words b, c and d are the input words a, b and c. The output words f, g and h are the input words e, f and g.
- R7: `outKw` equals `NEXT_K + inNextW` mod 2^32, registered with the same valid input.
- R8: When `inValid` is 0, `outState`, `outKw` and `outNonce` hold their previous values.
- R9: Sixty-four stages chained back to back give, for every nonce, the result of 64 reference rounds. The results leave in input order, exactly 64 cycles after entry, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, clears the valid flag only |
| inValid | input | 1 | Input word set is valid |
| inNonce | input | 32 | Nonce tag carried along |
| inState | input | 256 | Working variables a..h, a in the top bits |
| inKw | input | 32 | Pre-summed round constant plus schedule word for this round |
| inNextW | input | 32 | Schedule word of the following round |
| outValid | output | 1 | Output valid |
| outNonce | output | 32 | Nonce tag of the output |
| outState | output | 256 | Updated working variables |
| outKw | output | 32 | Pre-summed constant plus word for the following round |

## Verification
The assertions check four things on every cycle: valid follows the input one cycle later, the nonce and the shifted words pass through, and the state holds while no valid input arrives. They also check that the difference between the new `a` and the new `e` always equals S0+Maj−d of the captured inputs, which ties the two fused trees to each other. Only the bench scenarios can show that each fused sum has the right absolute value, including the all-ones carry extremes. They also show that data stays frozen through reset, and that a 64-stage chain with gaps in its input stream matches the reference in order and with the right latency.

// File: rtl/sha_round_pkg.sv
package sha_round_pkg;
  localparam int WORD_W = 32;
  localparam int NUM_VARS = 8;
  localparam int STATE_W = WORD_W * NUM_VARS;

  // fixed rotation amounts of the two big sigma functions
  localparam int S0_R0 = 2;
  localparam int S0_R1 = 13;
  localparam int S0_R2 = 22;
  localparam int S1_R0 = 6;
  localparam int S1_R1 = 11;
  localparam int S1_R2 = 25;

  typedef struct packed {
    logic capture;
  } stageStrobes_t;

  function automatic logic [WORD_W-1:0] rotr(input logic [WORD_W-1:0] x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic logic [WORD_W-1:0] bigSigma0(input logic [WORD_W-1:0] x);
    return rotr(x, S0_R0) ^ rotr(x, S0_R1) ^ rotr(x, S0_R2);
  endfunction

  function automatic logic [WORD_W-1:0] bigSigma1(input logic [WORD_W-1:0] x);
    return rotr(x, S1_R0) ^ rotr(x, S1_R1) ^ rotr(x, S1_R2);
  endfunction

  function automatic logic [WORD_W-1:0] choose(input logic [WORD_W-1:0] e, f, g);
    return (e & f) ^ (~e & g);
  endfunction

  function automatic logic [WORD_W-1:0] majority(input logic [WORD_W-1:0] a, b, c);
    return (a & b) ^ (a & c) ^ (b & c);
  endfunction
endpackage

// File: rtl/sha_csa3.sv
module sha_csa3 #(
  parameter int W = 32
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [W-1:0] opC,
  output logic [W-1:0] sumOut,
  output logic [W-1:0] carryOut
);
  assign carryOut[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : gen_bit
    assign sumOut[i] = opA[i] ^ opB[i] ^ opC[i];
    if (i < W - 1) begin : gen_carry
      assign carryOut[i+1] = (opA[i] & opB[i]) | (opA[i] & opC[i]) | (opB[i] & opC[i]);
    end
  end
endmodule

// File: rtl/sha_ripple_add.sv
module sha_ripple_add #(
  parameter int W = 32
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] sumOut
);
  logic [W-1:0] carry;
  assign carry[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : gen_fa
    assign sumOut[i] = opA[i] ^ opB[i] ^ carry[i];
    if (i < W - 1) begin : gen_chain
      assign carry[i+1] = (opA[i] & opB[i]) | (carry[i] & (opA[i] ^ opB[i]));
    end
  end
endmodule

// File: rtl/sha_round_ctrl.sv
module sha_round_ctrl
  import sha_round_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          inValid,
  output stageStrobes_t strobes,
  output logic          outValid
);
  logic validQ;

  always_ff @(posedge clk) begin
    if (rst) validQ <= 1'b0;
    else     validQ <= inValid;
  end

  always_comb begin
    strobes.capture = inValid & ~rst;
  end

  assign outValid = validQ;

  assert_reset_clears_valid_R1: assert property (@(posedge clk) rst |=> !outValid);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  assert_invalid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);
endmodule

// File: rtl/sha_round_datapath.sv
module sha_round_datapath
  import sha_round_pkg::*;
#(
  parameter logic [WORD_W-1:0] NEXT_K = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  stageStrobes_t       strobes,
  input  logic [WORD_W-1:0]   inNonce,
  input  logic [STATE_W-1:0]  inState,
  input  logic [WORD_W-1:0]   inKw,
  input  logic [WORD_W-1:0]   inNextW,
  output logic [WORD_W-1:0]   outNonce,
  output logic [STATE_W-1:0]  outState,
  output logic [WORD_W-1:0]   outKw
);
  logic [WORD_W-1:0] varA, varB, varC, varD, varE, varF, varG, varH;
  assign {varA, varB, varC, varD, varE, varF, varG, varH} = inState;

  logic [WORD_W-1:0] sig0, sig1, chVal, majVal;
  assign sig0   = bigSigma0(varA);
  assign sig1   = bigSigma1(varE);
  assign chVal  = choose(varE, varF, varG);
  assign majVal = majority(varA, varB, varC);

  // T1 kept in carry-save form: h + S1 + Ch + kw
  logic [WORD_W-1:0] t1PartS, t1PartC, t1Sum, t1Carry;
  sha_csa3 #(.W(WORD_W)) u_t1First (
    .opA(varH), .opB(sig1), .opC(chVal), .sumOut(t1PartS), .carryOut(t1PartC));
  sha_csa3 #(.W(WORD_W)) u_t1Second (
    .opA(t1PartS), .opB(t1PartC), .opC(inKw), .sumOut(t1Sum), .carryOut(t1Carry));

  // new e = d + T1, one compressor then one resolve
  logic [WORD_W-1:0] eSum, eCarry, newE;
  sha_csa3 #(.W(WORD_W)) u_eTree (
    .opA(t1Sum), .opB(t1Carry), .opC(varD), .sumOut(eSum), .carryOut(eCarry));
  sha_ripple_add #(.W(WORD_W)) u_eResolve (
    .opA(eSum), .opB(eCarry), .sumOut(newE));

  // new a = T1 + S0 + Maj, 4:2 compression then one resolve
  logic [WORD_W-1:0] aPartS, aPartC, aSum, aCarry, newA;
  sha_csa3 #(.W(WORD_W)) u_aFirst (
    .opA(t1Sum), .opB(t1Carry), .opC(sig0), .sumOut(aPartS), .carryOut(aPartC));
  sha_csa3 #(.W(WORD_W)) u_aSecond (
    .opA(aPartS), .opB(aPartC), .opC(majVal), .sumOut(aSum), .carryOut(aCarry));
  sha_ripple_add #(.W(WORD_W)) u_aResolve (
    .opA(aSum), .opB(aCarry), .sumOut(newA));

  // constant plus word for the following round, one stage early
  logic [WORD_W-1:0] kwNext;
  sha_ripple_add #(.W(WORD_W)) u_kwAdd (
    .opA(NEXT_K), .opB(inNextW), .sumOut(kwNext));

  always_ff @(posedge clk) begin
    if (strobes.capture) begin
      outState <= {newA, varA, varB, varC, newE, varE, varF, varG};
      outKw    <= kwNext;
      outNonce <= inNonce;
    end
  end

  assert_nonce_carried_R3: assert property (@(posedge clk) disable iff (rst)
    strobes.capture |=> outNonce == $past(inNonce));
  assert_fused_difference_R4: assert property (@(posedge clk) disable iff (rst)
    strobes.capture |=> (outState[255:224] - outState[127:96]) ==
      $past(bigSigma0(inState[255:224]) +
            majority(inState[255:224], inState[223:192], inState[191:160]) -
            inState[159:128]));
  assert_words_shift_R6: assert property (@(posedge clk) disable iff (rst)
    strobes.capture |=> (outState[223:128] == $past(inState[255:160])) &&
                        (outState[95:0] == $past(inState[127:32])));
  assert_next_kw_R7: assert property (@(posedge clk) disable iff (rst)
    strobes.capture |=> outKw == $past(inNextW) + NEXT_K);
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !strobes.capture |=> $stable(outState) && $stable(outKw) && $stable(outNonce));
endmodule

// File: rtl/sha256_fused_round.sv
module sha256_fused_round
  import sha_round_pkg::*;
#(
  parameter logic [31:0] NEXT_K = 32'h71374491
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic [31:0]  inNonce,
  input  logic [255:0] inState,
  input  logic [31:0]  inKw,
  input  logic [31:0]  inNextW,
  output logic         outValid,
  output logic [31:0]  outNonce,
  output logic [255:0] outState,
  output logic [31:0]  outKw
);
  stageStrobes_t strobes;

  sha_round_ctrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .strobes(strobes), .outValid(outValid));

  sha_round_datapath #(.NEXT_K(NEXT_K)) u_datapath (
    .clk(clk), .rst(rst), .strobes(strobes), .inNonce(inNonce), .inState(inState),
    .inKw(inKw), .inNextW(inNextW), .outNonce(outNonce), .outState(outState),
    .outKw(outKw));
endmodule

// File: tb/sha256_fused_round_bench.sv
`timescale 1ns/1ps
module sha256_fused_round_bench;
  localparam logic [31:0] UNIT_NK = 32'h71374491;
  localparam int STAGES = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cycleCount = 0;
  bit finished = 0;
  always @(posedge clk) cycleCount <= cycleCount + 1;

  // ---------------- reference functions ----------------
  function automatic logic [31:0] ror(input logic [31:0] x, input int n);
    logic [63:0] dbl;
    dbl = {x, x} >> n;
    return dbl[31:0];
  endfunction

  function automatic logic [255:0] refRound(input logic [255:0] s, input logic [31:0] kw);
    logic [31:0] a, b, c, d, e, f, g, h, t1, t2;
    {a, b, c, d, e, f, g, h} = s;
    t1 = h + (ror(e, 6) ^ ror(e, 11) ^ ror(e, 25)) + ((e & f) | (~e & g)) + kw;
    t2 = (ror(a, 2) ^ ror(a, 13) ^ ror(a, 22)) + ((a & b) | (c & (a | b)));
    return {t1 + t2, a, b, c, d + t1, e, f, g};
  endfunction

  function automatic logic [31:0] benchK(input int i);
    return 32'h428a2f98 ^ (32'(i) * 32'h9e3779b9) ^ {i[7:0], 24'h000000};
  endfunction

  function automatic logic [31:0] benchW(input logic [31:0] n, input int t);
    return (n * 32'(t + 1)) ^ ror(32'h5be0cd19, t % 32);
  endfunction

  function automatic logic [255:0] initState(input logic [31:0] n);
    return {n ^ 32'h6a09e667, ~n, n + 32'd1, 32'hbb67ae85,
            {n[15:0], n[31:16]}, n ^ 32'hffff0000, 32'h00000000, n};
  endfunction

  function automatic logic [255:0] refHash(input logic [31:0] n);
    logic [255:0] s;
    s = initState(n);
    for (int t = 0; t < STAGES; t++) s = refRound(s, benchK(t) + benchW(n, t));
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- single stage ----------------
  logic         uValid = 1'b0;
  logic [31:0]  uNonce = '0;
  logic [255:0] uState = '0;
  logic [31:0]  uKw = '0;
  logic [31:0]  uNextW = '0;
  logic         uOutValid;
  logic [31:0]  uOutNonce;
  logic [255:0] uOutState;
  logic [31:0]  uOutKw;

  sha256_fused_round #(.NEXT_K(UNIT_NK)) u_sha256_fused_round (
    .clk(clk), .rst(rst), .inValid(uValid), .inNonce(uNonce), .inState(uState),
    .inKw(uKw), .inNextW(uNextW), .outValid(uOutValid), .outNonce(uOutNonce),
    .outState(uOutState), .outKw(uOutKw));

  // ---------------- 64-stage chain ----------------
  logic         feedValid = 1'b0;
  logic [31:0]  feedNonce = '0;
  logic         chValid [0:STAGES];
  logic [31:0]  chNonce [0:STAGES];
  logic [255:0] chState [0:STAGES];
  logic [31:0]  chKw    [0:STAGES];

  assign chValid[0] = feedValid;
  assign chNonce[0] = feedNonce;
  assign chState[0] = initState(feedNonce);
  assign chKw[0]    = benchK(0) + benchW(feedNonce, 0);

  for (genvar i = 0; i < STAGES; i++) begin : gen_chain
    logic [31:0] nextWord;
    assign nextWord = benchW(chNonce[i], i + 1);
    sha256_fused_round #(.NEXT_K(benchK(i + 1))) u_stage (
      .clk(clk), .rst(rst), .inValid(chValid[i]), .inNonce(chNonce[i]),
      .inState(chState[i]), .inKw(chKw[i]), .inNextW(nextWord),
      .outValid(chValid[i+1]), .outNonce(chNonce[i+1]),
      .outState(chState[i+1]), .outKw(chKw[i+1]));
  end

  logic [31:0] sentNonce [$];
  int          sentCycle [$];
  int          receivedCount = 0;

  always @(negedge clk) begin
    if (!rst && chValid[STAGES]) begin
      logic [31:0] expN;
      int expC;
      receivedCount++;
      if (sentNonce.size() == 0) begin
        check(1'b0, "R9 unexpected output", {224'h0, chNonce[STAGES]}, 256'h0);
      end else begin
        expN = sentNonce.pop_front();
        expC = sentCycle.pop_front();
        check(chNonce[STAGES] == expN, "R9 order", {224'h0, chNonce[STAGES]}, {224'h0, expN});
        check(cycleCount == expC + STAGES, "R9 latency", 256'(cycleCount), 256'(expC + STAGES));
        check(chState[STAGES] == refHash(expN), "R9 chained result",
              chState[STAGES], refHash(expN));
      end
    end
  end

  // ---------------- unit vector task ----------------
  task automatic unitVector(input logic [255:0] s, input logic [31:0] kw,
                            input logic [31:0] nw, input logic [31:0] n);
    logic [255:0] exp;
    logic [31:0] d, h, sig1, ch;
    @(negedge clk);
    uValid = 1'b1; uState = s; uKw = kw; uNextW = nw; uNonce = n;
    @(negedge clk);
    uValid = 1'b0;
    exp = refRound(s, kw);
    d = s[159:128]; h = s[31:0];
    sig1 = ror(s[127:96], 6) ^ ror(s[127:96], 11) ^ ror(s[127:96], 25);
    ch = (s[127:96] & s[95:64]) | (~s[127:96] & s[63:32]);
    check(uOutValid == 1'b1, "R2 valid after one cycle", 256'(uOutValid), 256'd1);
    check(uOutState[255:224] == exp[255:224], "R4 new a",
          256'(uOutState[255:224]), 256'(exp[255:224]));
    check(uOutState[127:96] == d + h + sig1 + ch + kw, "R5 new e",
          256'(uOutState[127:96]), 256'(d + h + sig1 + ch + kw));
    check({uOutState[223:128], uOutState[95:0]} == {s[255:160], s[127:32]}, "R6 shifted words",
          256'({uOutState[223:128], uOutState[95:0]}), 256'({s[255:160], s[127:32]}));
    check(uOutKw == UNIT_NK + nw, "R7 next kw", 256'(uOutKw), 256'(UNIT_NK + nw));
    check(uOutNonce == n, "R3 nonce", 256'(uOutNonce), 256'(n));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [255:0] heldState;
    logic [31:0] heldKw, heldNonce;
    int fed;
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    check(uOutValid == 1'b0, "R1 valid low in reset", 256'(uOutValid), 256'd0);
    rst = 1'b0;

    // directed carry extremes and patterns
    unitVector({256{1'b1}}, 32'hffffffff, 32'hffffffff, 32'hffffffff);
    unitVector({256{1'b0}}, 32'h00000000, 32'h00000000, 32'h00000000);
    unitVector({8{32'haaaa5555}}, 32'h80000000, 32'h8ec86b6f, 32'h12345678);
    for (int k = 0; k < 20; k++) begin
      unitVector({$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom},
                 $urandom, $urandom, $urandom);
    end

    // R8: idle input must not change data
    heldState = uOutState; heldKw = uOutKw; heldNonce = uOutNonce;
    @(negedge clk);
    uValid = 1'b0; uState = ~heldState; uKw = ~heldKw; uNextW = 32'h13579bdf; uNonce = ~heldNonce;
    @(negedge clk);
    check(uOutValid == 1'b0, "R2 idle gives invalid", 256'(uOutValid), 256'd0);
    check(uOutState == heldState, "R8 state held", uOutState, heldState);
    check(uOutKw == heldKw && uOutNonce == heldNonce, "R8 kw and nonce held",
          256'({uOutKw, uOutNonce}), 256'({heldKw, heldNonce}));

    // R1: reset with valid data clears valid only and freezes data
    uValid = 1'b1; rst = 1'b1;
    @(negedge clk);
    check(uOutValid == 1'b0, "R1 reset clears valid", 256'(uOutValid), 256'd0);
    check(uOutState == heldState, "R1 state kept through reset", uOutState, heldState);
    check(uOutKw == heldKw && uOutNonce == heldNonce, "R1 kw and nonce kept",
          256'({uOutKw, uOutNonce}), 256'({heldKw, heldNonce}));
    uValid = 1'b0; rst = 1'b0;

    // R9: stream through the 64-stage chain
    fed = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (k < 3) begin
        feedValid = 1'b1;
        feedNonce = (k == 0) ? 32'h00000000 : (k == 1) ? 32'hffffffff : 32'h80000000;
      end else if (k < 100) begin
        feedValid = 1'b1;
        feedNonce = $urandom;
      end else begin
        feedValid = ($urandom % 4) != 0;
        feedNonce = $urandom;
      end
      if (feedValid) begin
        sentNonce.push_back(feedNonce);
        sentCycle.push_back(cycleCount);
        fed++;
      end
    end
    @(negedge clk);
    feedValid = 1'b0;
    repeat (STAGES + 4) @(negedge clk);
    check(receivedCount == fed, "R9 result count", 256'(receivedCount), 256'(fed));

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule